// File: doc/BRIEF.md
# Load-Use Hazard Detection Unit

This block lives in the decode stage of a five-stage in-order pipeline. Each cycle it checks whether the instruction in the execute stage is a load whose target register is named as a source by the instruction now being decoded. The loaded value only exists after the memory stage, so even a forwarding network cannot deliver it to the dependent instruction's execute step in time.

When it finds such a pair, the unit stalls the pipeline for one cycle. It holds the program counter and the fetch/decode pipeline register so the dependent instruction is decoded again and its successor is fetched again. It also tells the decode stage to write all-zero control bits into the decode/execute register, so a no-op bubble flows down the execute, memory and write-back stages. One cycle later the load has reached the memory stage and the normal forwarding path can supply its result. The unit is combinational from its data inputs to its outputs. Reset only forces its outputs to the non-stalling state.

Top module: `luh_hazard_unit`

## Requirements
- R1: When the execute-stage load flag is 1 and the execute-stage target register index equals the decode-stage first source index, the stall output is 1 in the same cycle.
- R2: When the execute-stage load flag is 1 and the target index equals the decode-stage second source index, the stall output is 1 in the same cycle. A target that matches both sources also stalls.
- R3: When the execute-stage load flag is 0, the stall output is 0 whatever the register indices are.
- R4: When the load flag is 1 but the target index matches neither source index, the stall output is 0. This includes the highest index value (all ones).
- R5: The PC write enable and the fetch/decode write enable are each the inverse of the stall output (1 = write), and the control-zero output equals the stall output. All three follow the inputs with no clock latency.
- R6: While the active-low reset is 0, the stall output is 0 and both write enables are 1, even if the inputs form a load-use match.
- R7: In a pipeline where the zeroed control bits replace the load flag on the next cycle and the held decode register presents the same source indices again, each load-use pair produces exactly one stall cycle, followed by a non-stall cycle for the same instruction.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, used to sample the reset and the built-in checks |
| rst_n | input | 1 | Synchronous active-low reset; forces the non-stall state |
| ex_is_load | input | 1 | The instruction in the execute stage reads data memory |
| ex_dst_idx | input | REG_AW | Target register index of the execute-stage instruction |
| id_src_a_idx | input | REG_AW | First source register index of the decode-stage instruction |
| id_src_b_idx | input | REG_AW | Second source register index of the decode-stage instruction |
| pc_we | output | 1 | Program counter write enable (0 holds the PC) |
| ifid_we | output | 1 | Fetch/decode register write enable (0 holds it) |
| ctrl_zero | output | 1 | Forces the control bits entering decode/execute to zero |

## Verification
The hardest situation to reach from the ports is the cycle right after a stall. There the same decoded instruction must be seen again, with a bubble instead of the load ahead of it, and the unit must not stall a second time. Free random index values almost never line up a load with a matching source, and driving the ports directly does not reproduce the bubble. The bench therefore runs a small pipeline model that feeds the unit's outputs back into its own fetch/decode and decode/execute registers. It draws register indices from a narrow range so that load-use pairs are frequent. Directed vectors separately cover each source matching, both matching, the all-ones index and a match held during reset.

// File: rtl/luh_pkg.sv
// Package luh_pkg
// Shared types for the load-use hazard unit. Assumes at most a few
// source operands per decoded instruction.
package luh_pkg;

    // Which source operand caused a stall, for readability of the decision logic.
    typedef enum logic [1:0] {
        HIT_NONE = 2'b00,
        HIT_A    = 2'b01,
        HIT_B    = 2'b10,
        HIT_BOTH = 2'b11
    } hit_kind_e;

endpackage

// File: rtl/luh_reg_match.sv
// Module luh_reg_match
// Compares one target register index against a packed list of source
// register indices and flags every source that is equal. Purely
// combinational. Assumes the sources are packed lowest-first.
module luh_reg_match #(
    parameter int REG_AW  = 5,
    parameter int NUM_SRC = 2
) (
    input  logic [REG_AW-1:0]         dst_idx,
    input  logic [NUM_SRC*REG_AW-1:0] src_idx,
    output logic [NUM_SRC-1:0]        hit
);

    // One equality comparator per source operand.
    for (genvar s = 0; s < NUM_SRC; s++) begin : g_cmp
        assign hit[s] = (src_idx[s*REG_AW +: REG_AW] == dst_idx);
    end

endmodule

// File: rtl/luh_stall_ctrl.sv
// Module luh_stall_ctrl
// Turns operand matches and the execute-stage load flag into the stall
// decision and the three pipeline control outputs. Assumes the reset is
// synchronous and active low and only has to hold the outputs idle.
module luh_stall_ctrl #(
    parameter int NUM_SRC = 2
) (
    input  logic               rst_n,
    input  logic               ex_is_load,
    input  logic [NUM_SRC-1:0] hit,
    output logic               stall,
    output logic               pc_we,
    output logic               ifid_we,
    output logic               ctrl_zero
);

    logic any_hit;

    // A stall needs a load in execute and at least one matching source.
    always_comb begin
        any_hit = |hit;
        stall   = rst_n && ex_is_load && any_hit;
    end

    // Freeze fetch and decode and zero the next control bundle on a stall.
    always_comb begin
        pc_we     = !stall;
        ifid_we   = !stall;
        ctrl_zero = stall;
    end

endmodule

// File: rtl/luh_hazard_unit.sv
// Module luh_hazard_unit
// Decode-stage load-use hazard detector. Stalls one cycle when the
// execute-stage load targets a register the decoded instruction reads.
// Assumes forwarding from the memory stage resolves the dependence after
// the bubble, and that the decode stage applies ctrl_zero to ID/EX.
module luh_hazard_unit #(
    parameter int REG_AW  = 5,
    parameter int NUM_SRC = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ex_is_load,
    input  logic [REG_AW-1:0] ex_dst_idx,
    input  logic [REG_AW-1:0] id_src_a_idx,
    input  logic [REG_AW-1:0] id_src_b_idx,
    output logic              pc_we,
    output logic              ifid_we,
    output logic              ctrl_zero
);

    import luh_pkg::*;

    localparam int SRC_BUS_W = NUM_SRC * REG_AW;

    logic [SRC_BUS_W-1:0] src_bus;
    logic [NUM_SRC-1:0]   hit;
    logic                 stall;
    hit_kind_e            hit_kind;

    // Pack the two decode-stage sources, first source in the low slot.
    always_comb begin
        src_bus = '0;
        src_bus[REG_AW-1:0] = id_src_a_idx;
        if (NUM_SRC > 1) src_bus[SRC_BUS_W-1 -: REG_AW] = id_src_b_idx;
    end

    luh_reg_match #(.REG_AW(REG_AW), .NUM_SRC(NUM_SRC)) match_i (
        .dst_idx (ex_dst_idx),
        .src_idx (src_bus),
        .hit     (hit)
    );

    luh_stall_ctrl #(.NUM_SRC(NUM_SRC)) ctrl_i (
        .rst_n      (rst_n),
        .ex_is_load (ex_is_load),
        .hit        (hit),
        .stall      (stall),
        .pc_we      (pc_we),
        .ifid_we    (ifid_we),
        .ctrl_zero  (ctrl_zero)
    );

    // Classify the cause for the checks below.
    always_comb begin
        hit_kind = hit_kind_e'({(ex_dst_idx == id_src_b_idx), (ex_dst_idx == id_src_a_idx)});
    end

    // R6: reset holds the non-stalling outputs.
    always_comb begin
        if (!rst_n) begin
            a_r6_reset_idle: assert (!ctrl_zero && pc_we && ifid_we);
        end
    end

    a_r1_src_a_stalls: assert property (@(posedge clk) disable iff (!rst_n)
        (ex_is_load && (hit_kind == HIT_A || hit_kind == HIT_BOTH)) |-> ctrl_zero);

    a_r2_src_b_stalls: assert property (@(posedge clk) disable iff (!rst_n)
        (ex_is_load && (hit_kind == HIT_B || hit_kind == HIT_BOTH)) |-> ctrl_zero);

    a_r3_no_load_no_stall: assert property (@(posedge clk) disable iff (!rst_n)
        !ex_is_load |-> !ctrl_zero);

    a_r4_no_match_no_stall: assert property (@(posedge clk) disable iff (!rst_n)
        (hit_kind == HIT_NONE) |-> !ctrl_zero);

    a_r5_enables_follow: assert property (@(posedge clk) disable iff (!rst_n)
        (pc_we == !ctrl_zero) && (ifid_we == !ctrl_zero));

    a_r7_single_bubble: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_zero |=> !ctrl_zero);

    a_r7_same_decode: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_zero |=> ($stable(id_src_a_idx) && $stable(id_src_b_idx)));

endmodule

// File: tb/luh_hazard_unit_tb_top.sv
`timescale 1ns/1ps
module luh_hazard_unit_tb_top;

    localparam int AW = 5;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          ld;
    logic [AW-1:0] dst, sa, sb;
    logic          pc_we, ifid_we, ctrl_zero;

    int checks = 0;
    int errors = 0;
    int stalls_seen = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    luh_hazard_unit #(.REG_AW(AW), .NUM_SRC(2)) dut_i (
        .clk(clk), .rst_n(rst_n), .ex_is_load(ld), .ex_dst_idx(dst),
        .id_src_a_idx(sa), .id_src_b_idx(sb),
        .pc_we(pc_we), .ifid_we(ifid_we), .ctrl_zero(ctrl_zero)
    );

    function automatic logic exp_stall(logic r, logic m, logic [AW-1:0] d, logic [AW-1:0] a, logic [AW-1:0] b);
        return r && m && ((d == a) || (d == b));
    endfunction

    task automatic chk(string req, logic act, logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0b expected=%0b", req, act, exp);
        end
    endtask

    // R5: all three outputs against the expected stall.
    task automatic check_all(string req);
        logic e;
        e = exp_stall(rst_n, ld, dst, sa, sb);
        chk({req, " ctrl_zero"}, ctrl_zero, e);
        chk({req, " R5 pc_we"}, pc_we, !e);
        chk({req, " R5 ifid_we"}, ifid_we, !e);
    endtask

    // Directed vector, then a no-load vector with the same sources.
    task automatic vec(string req, logic m, logic [AW-1:0] d, logic [AW-1:0] a, logic [AW-1:0] b);
        @(negedge clk); ld = m; dst = d; sa = a; sb = b; #1;
        check_all(req);
        @(negedge clk); ld = 1'b0; #1;
        check_all("R3 settle");
    endtask

    initial begin
        #(20.0 * 200000);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        logic          if_ld, ex_ld, prev_stall, e;
        logic [AW-1:0] if_rs, if_rt, ex_rt;
        void'($urandom(32'd4242));
        rst_n = 1'b0; ld = 1'b1; dst = 5'd3; sa = 5'd3; sb = 5'd3;
        @(negedge clk); #1;
        chk("R6 reset ctrl_zero", ctrl_zero, 1'b0);
        chk("R6 reset pc_we", pc_we, 1'b1);
        chk("R6 reset ifid_we", ifid_we, 1'b1);
        @(negedge clk); rst_n = 1'b1; ld = 1'b0; #1;
        check_all("R6 release");

        vec("R1 src_a hit", 1'b1, 5'd7, 5'd7, 5'd2);
        vec("R2 src_b hit", 1'b1, 5'd9, 5'd1, 5'd9);
        vec("R2 both hit", 1'b1, 5'd31, 5'd31, 5'd31);
        vec("R3 no load match", 1'b0, 5'd4, 5'd4, 5'd4);
        vec("R4 no match", 1'b1, 5'd31, 5'd30, 5'd0);
        vec("R4 zero target", 1'b1, 5'd0, 5'd1, 5'd2);

        // R7: pipeline model feeding the unit's decisions back.
        if_ld = 1'b0; if_rs = 5'd1; if_rt = 5'd2; ex_ld = 1'b0; ex_rt = 5'd0;
        prev_stall = 1'b0;
        for (int i = 0; i < 400; i++) begin
            @(negedge clk);
            ld = ex_ld; dst = ex_rt; sa = if_rs; sb = if_rt; #1;
            e = exp_stall(1'b1, ex_ld, ex_rt, if_rs, if_rt);
            check_all("R1 R2 R4 model");
            if (prev_stall) chk("R7 one bubble only", ctrl_zero, 1'b0);
            if (e) stalls_seen++;
            prev_stall = e;
            if (e) begin
                ex_ld = 1'b0; ex_rt = 5'd0;
            end else begin
                ex_ld = if_ld; ex_rt = if_rt;
                if_ld = 1'($urandom_range(1, 0));
                if_rs = AW'($urandom_range(3, 0));
                if_rt = AW'($urandom_range(3, 0));
            end
        end
        chk("R7 stalls exercised", stalls_seen > 10, 1'b1);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule